// File: doc/BRIEF.md
# Buck Regulator Sequencing and Protection Controller

This block is the control state machine of a single-phase buck regulator. It brings the rail up from an idle state through a fixed start-up delay and a linear soft-start ramp of the reference, then declares the rail ready once the reference has stayed on target for a settling interval. While it runs, it watches the digitized output voltage against the reference and two over-current comparator flags. It decides when the high-side and low-side switches may follow the modulator's request, and when they must be held off or clamped.

Faults come in two kinds. Those that shut the rail down latch until the enable input is taken low: a fast over-current, a slow over-current that persists, and an over-voltage above a margin over the reference. An under-voltage condition and all protections seen during soft start only act while they last. During an over-voltage shutdown the reference is ramped down to zero. The low-side switch then tracks the output against the falling threshold, and it is clamped on once the reference reaches zero. All voltages are codes of 1 mV per LSB. All timing is counted in pulses of a one-microsecond tick input.

Top module: `reg_seq_ctrl`

## Requirements
- R1: After reset, and while the enable input is low or either supply flag is low, ready, both gate enables and the reference output are 0. The sequence starts only when the enable input and both supply flags are high.
- R2: After start, the reference stays at 0 with both gates off for STARTUP_US ticks (20). It then rises by SS_STEP (14 codes) per tick and saturates exactly at the target, never above it.
- R3: Ready is high only in normal operation. It rises READY_US (50) ticks, with one tick of tolerance, after the reference first equals the target. It is low throughout start-up delay and soft start.
- R4: In normal operation, ready is low while the output is more than UV_OFS (300) codes below the reference. A gap of exactly 300 codes keeps ready high, and ready returns to high when the gap closes. This is not latched.
- R5: A slow over-current flag held for OC_US (50) consecutive ticks in normal operation causes a latched shutdown, with ready low and both gates off. A shorter episode has no effect.
- R6: A fast over-current flag in normal operation shuts down at the next clock edge: ready drops at that edge and both gates are off within a few cycles. The shutdown is latched.
- R7: The over-voltage limit depends on the state. In soft start it is an absolute OV_ABS (2900 codes), and crossing it only forces high-side off and low-side on while it lasts. In normal operation it is the reference plus OV_OFS (400 codes), with exactly +400 not tripping, and crossing it latches an over-voltage shutdown.
- R8: In over-voltage shutdown the high-side gate is off and the reference falls by OV_STEP (3 codes) per tick down to 0. The low-side gate is on while the output exceeds the reference plus OV_OFS, off otherwise, and held on once the reference is 0.
- R9: A latched over-current or over-voltage shutdown persists while enable stays high, even after its cause is removed. A low level on enable returns the block to idle, and a later high level runs the full sequence again.
- R10: Loss of either supply flag during start-up, soft start or normal operation returns to idle: ready low, gates off, reference 0. Restoring the supplies restarts the start-up delay and soft start.
- R11: While switching is allowed, the high-side gate follows pwm_i = 1 and the low-side gate follows pwm_i = 0. The two gates are never on in the same cycle, and at least one cycle with both off separates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| en_i | input | 1 | Regulator enable |
| vcc_ok_i | input | 1 | Controller supply above lockout |
| vin_ok_i | input | 1 | Power input above lockout |
| target_i | input | W (12) | Target reference, 1 mV per code |
| vout_i | input | W (12) | Digitized output voltage, 1 mV per code |
| oc_slow_i | input | 1 | Output of the delayed over-current comparator |
| oc_fast_i | input | 1 | Output of the immediate over-current comparator |
| pwm_i | input | 1 | Modulator request: 1 high-side, 0 low-side |
| ready_o | output | 1 | Rail in regulation |
| hs_en_o | output | 1 | High-side switch enable |
| ls_en_o | output | 1 | Low-side switch enable |
| ref_o | output | W (12) | Current reference code |

## Verification
The assertions take the tick input to be a single-cycle pulse separated by idle cycles, so that at most one ramp step or timer increment happens per tick. They also take the comparator flags and the output code to be synchronous to the clock. The bench generates the tick from the clock as one high cycle in every four, and it changes every input only at the falling edge. In most scenarios it derives the output code from the reference output plus a chosen offset, so that each threshold can be placed exactly at its boundary and one code beyond it.

// File: rtl/reg_seq_pkg.sv
package reg_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_START,
    ST_SOFT,
    ST_RUN,
    ST_OC,
    ST_OV
  } seq_state_e;

  typedef enum logic [1:0] {
    RM_HOLD,
    RM_TRACK,
    RM_FALL
  } ramp_mode_e;
endpackage

// File: rtl/seq_ref_ramp.sv
module seq_ref_ramp
  import reg_seq_pkg::*;
#(
  parameter int W       = 12,
  parameter int UP_STEP = 14,
  parameter int DN_STEP = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  ramp_mode_e   mode_i,
  input  logic [W-1:0] target_i,
  output logic [W-1:0] ref_o,
  output logic         at_target_o
);
  localparam logic [W-1:0] STEP_U = W'(UP_STEP);
  localparam logic [W-1:0] STEP_D = W'(DN_STEP);

  logic [W-1:0] ref_q, ref_d;

  always_comb begin
    ref_d = ref_q;
    if (clr_i) begin
      ref_d = '0;
    end else if (tick_i) begin
      unique case (mode_i)
        RM_TRACK: begin
          if (ref_q < target_i)
            ref_d = (target_i - ref_q > STEP_U) ? ref_q + STEP_U : target_i;
          else if (ref_q > target_i)
            ref_d = (ref_q - target_i > STEP_U) ? ref_q - STEP_U : target_i;
        end
        RM_FALL: ref_d = (ref_q > STEP_D) ? ref_q - STEP_D : '0;
        default: ref_d = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= ref_d;
  end

  assign ref_o       = ref_q;
  assign at_target_o = (ref_q == target_i);

  // R2
  ref_step_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(ref_q));
  // R8
  ref_fall_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RM_FALL && !clr_i) |=> (ref_q <= $past(ref_q)));
endmodule

// File: rtl/seq_oc_timer.sv
module seq_oc_timer #(
  parameter int OC_US = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic arm_i,
  output logic expire_o
);
  localparam int CW = $clog2(OC_US + 1);
  localparam logic [CW-1:0] LIMIT = CW'(OC_US);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!arm_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = arm_i && (cnt_q == LIMIT);

  // R5
  oc_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  // R5
  oc_no_early_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !expire_o);
endmodule

// File: rtl/seq_gate_ctrl.sv
module seq_gate_ctrl #(
  parameter int DEAD_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_req_i,
  input  logic ls_req_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int DCW = $clog2(DEAD_CYC + 1);
  localparam logic [DCW-1:0] DEAD_LD = DCW'(DEAD_CYC);

  logic [1:0]     want, cur_q;
  logic [DCW-1:0] dead_q;

  assign want = {hs_req_i & ~ls_req_i, ls_req_i & ~hs_req_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      dead_q <= '0;
    end else if (cur_q != 2'b00 && want != cur_q) begin
      cur_q  <= '0;
      dead_q <= DEAD_LD;
    end else if (cur_q == 2'b00) begin
      if (dead_q != '0) dead_q <= dead_q - 1'b1;
      else              cur_q  <= want;
    end
  end

  assign hs_o = cur_q[1];
  assign ls_o = cur_q[0];

  // R11
  gate_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
  // R11
  gate_dead_ls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_o) |-> !$past(hs_o));
  // R11
  gate_dead_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> !$past(ls_o));
endmodule

// File: rtl/reg_seq_ctrl.sv
module reg_seq_ctrl
  import reg_seq_pkg::*;
#(
  parameter int W          = 12,
  parameter int STARTUP_US = 20,
  parameter int SS_STEP    = 14,
  parameter int READY_US   = 50,
  parameter int OC_US      = 50,
  parameter int OV_ABS     = 2900,
  parameter int OV_OFS     = 400,
  parameter int UV_OFS     = 300,
  parameter int OV_STEP    = 3,
  parameter int DEAD_CYC   = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         us_tick_i,
  input  logic         en_i,
  input  logic         vcc_ok_i,
  input  logic         vin_ok_i,
  input  logic [W-1:0] target_i,
  input  logic [W-1:0] vout_i,
  input  logic         oc_slow_i,
  input  logic         oc_fast_i,
  input  logic         pwm_i,
  output logic         ready_o,
  output logic         hs_en_o,
  output logic         ls_en_o,
  output logic [W-1:0] ref_o
);
  localparam int XW   = W + 2;
  localparam int DMAX = (STARTUP_US > READY_US) ? STARTUP_US : READY_US;
  localparam int DW   = $clog2(DMAX + 1);
  localparam logic [DW-1:0] START_LAST = DW'(STARTUP_US - 1);
  localparam logic [DW-1:0] READY_LIM  = DW'(READY_US);
  localparam logic [XW-1:0] OV_ABS_X   = XW'(OV_ABS);
  localparam logic [XW-1:0] OV_OFS_X   = XW'(OV_OFS);
  localparam logic [XW-1:0] UV_OFS_X   = XW'(UV_OFS);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] dly_q;
  logic          ready_q;
  logic          supply_ok, at_target, oc_expire;
  logic          ov_rel, ov_abs, uv;
  logic          hs_req, ls_req, ramp_clr;
  ramp_mode_e    ramp_mode;
  logic [W-1:0]  ref_w;
  logic [XW-1:0] vout_x, ref_x;

  assign supply_ok = vcc_ok_i && vin_ok_i;
  assign vout_x    = XW'(vout_i);
  assign ref_x     = XW'(ref_w);
  assign ov_rel    = vout_x > ref_x + OV_OFS_X;
  assign ov_abs    = vout_x > OV_ABS_X;
  assign uv        = vout_x + UV_OFS_X < ref_x;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (en_i && supply_ok) state_d = ST_START;
      ST_START: begin
        if (!en_i || !supply_ok)                    state_d = ST_OFF;
        else if (us_tick_i && dly_q == START_LAST)  state_d = ST_SOFT;
      end
      ST_SOFT: begin
        if (!en_i || !supply_ok) state_d = ST_OFF;
        else if (at_target)      state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!en_i || !supply_ok)        state_d = ST_OFF;
        else if (oc_fast_i || oc_expire) state_d = ST_OC;
        else if (ov_rel)                 state_d = ST_OV;
      end
      ST_OC, ST_OV: if (!en_i) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      dly_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)
        dly_q <= '0;
      else if (us_tick_i && (state_q == ST_START ||
               (state_q == ST_RUN && at_target && dly_q < READY_LIM)))
        dly_q <= dly_q + 1'b1;
      ready_q <= (state_d == ST_RUN) && (state_q == ST_RUN) &&
                 (dly_q >= READY_LIM) && !uv;
    end
  end

  // reference ramp control
  always_comb begin
    ramp_clr  = (state_q == ST_OFF) || (state_q == ST_START);
    unique case (state_q)
      ST_SOFT, ST_RUN: ramp_mode = RM_TRACK;
      ST_OV:           ramp_mode = RM_FALL;
      default:         ramp_mode = RM_HOLD;
    endcase
  end

  // gate requests
  always_comb begin
    hs_req = 1'b0;
    ls_req = 1'b0;
    if (supply_ok) begin
      unique case (state_q)
        ST_SOFT, ST_RUN: begin
          if ((state_q == ST_SOFT) ? ov_abs : ov_rel) begin
            ls_req = 1'b1;
          end else if (!oc_fast_i) begin
            hs_req = pwm_i;
            ls_req = !pwm_i;
          end
        end
        ST_OV:   ls_req = (ref_w == '0) || ov_rel;
        default: ;
      endcase
    end
  end

  seq_ref_ramp #(.W(W), .UP_STEP(SS_STEP), .DN_STEP(OV_STEP)) u_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (us_tick_i),
    .clr_i      (ramp_clr),
    .mode_i     (ramp_mode),
    .target_i   (target_i),
    .ref_o      (ref_w),
    .at_target_o(at_target)
  );

  seq_oc_timer #(.OC_US(OC_US)) u_oc_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (us_tick_i),
    .arm_i   (oc_slow_i && state_q == ST_RUN),
    .expire_o(oc_expire)
  );

  seq_gate_ctrl #(.DEAD_CYC(DEAD_CYC)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hs_req_i(hs_req),
    .ls_req_i(ls_req),
    .hs_o    (hs_en_o),
    .ls_o    (ls_en_o)
  );

  assign ready_o = ready_q;
  assign ref_o   = ref_w;

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && !en_i) |=> (state_q == ST_OFF && !ready_o));
  // R3
  ready_only_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (state_q == ST_RUN));
  // R6
  fast_oc_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && en_i && supply_ok && oc_fast_i) |=>
      (state_q == ST_OC && !ready_o));
  // R8
  ov_hs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OV) |=> !hs_en_o);
  // R9
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_OC || state_q == ST_OV) && en_i) |=> $stable(state_q));
  // R10
  supply_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_ok && (state_q == ST_START || state_q == ST_SOFT || state_q == ST_RUN))
      |=> (state_q == ST_OFF));
endmodule

// File: tb/tb_reg_seq_ctrl.sv
`timescale 1ns/1ps
module tb_reg_seq_ctrl;
  localparam int W = 12;
  localparam int STARTUP_US = 20;
  localparam int SS_STEP = 14;
  localparam int READY_US = 50;
  localparam int OC_US = 50;
  localparam int OV_STEP = 3;
  localparam int TARGET = 1000;

  logic clk = 0, rst_n = 0, tick = 0, en = 0, vcc_ok = 1, vin_ok = 1;
  logic oc_slow = 0, oc_fast = 0, pwm = 0, pwm_auto = 1;
  logic [W-1:0] target = W'(TARGET);
  logic [W-1:0] vout, ref_v;
  logic ready, hs, ls;
  logic vmode = 0;
  int   ofs = 0;
  logic [W-1:0] vfix = '0;
  int checks = 0, errors = 0, overlap = 0;
  logic hs_prev = 0, ls_prev = 0;

  function automatic logic [W-1:0] clampv(input int v);
    if (v < 0) return '0;
    if (v > 4095) return '1;
    return W'(v);
  endfunction

  assign vout = vmode ? vfix : clampv(int'(ref_v) + ofs);

  reg_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .en_i(en),
    .vcc_ok_i(vcc_ok), .vin_ok_i(vin_ok), .target_i(target), .vout_i(vout),
    .oc_slow_i(oc_slow), .oc_fast_i(oc_fast), .pwm_i(pwm),
    .ready_o(ready), .hs_en_o(hs), .ls_en_o(ls), .ref_o(ref_v)
  );

  always #2 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  end

  initial forever begin
    repeat (5) @(negedge clk);
    if (pwm_auto) pwm = ~pwm;
  end

  // R11 overlap / dead-time monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if ((hs && ls) || (ls && hs_prev) || (hs && ls_prev)) overlap++;
    end
    hs_prev <= hs;
    ls_prev <= ls;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk iff tick);
    @(negedge clk);
  endtask

  task automatic wait_ready(output bit got);
    got = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (ready) begin got = 1; break; end
    end
  endtask

  task automatic bring_up(input string req);
    bit got;
    vmode = 0; ofs = 0;
    en = 1;
    wait_ready(got);
    check(got, req, "ready after restart", int'(ready), 1);
  endtask

  task automatic cycle_enable();
    en = 0; cyc(3); en = 1;
  endtask

  task automatic test_reset();
    cyc(2);
    check(!ready && !hs && !ls && ref_v == 0, "R1", "outputs in reset", int'(ready|hs|ls), 0);
    rst_n = 1;
    ticks(10);
    check(!ready && !hs && !ls, "R1", "idle with enable low", int'(ready|hs|ls), 0);
    check(ref_v == 0, "R1", "ref idle", int'(ref_v), 0);
    vcc_ok = 0; en = 1; ticks(5);
    check(ref_v == 0 && !hs && !ls, "R1", "no start without supply", int'(ref_v), 0);
    en = 0; vcc_ok = 1; cyc(2);
  endtask

  task automatic test_startup();
    int r0, r1, n;
    bit seen_hs, seen_ready, reached;
    en = 1;
    ticks(STARTUP_US - 2);
    check(ref_v == 0, "R2", "ref during startup delay", int'(ref_v), 0);
    check(!hs && !ls, "R2", "gates during startup delay", int'(hs|ls), 0);
    ticks(4);
    check(ref_v > 0, "R2", "ramp started", int'(ref_v), SS_STEP);
    r0 = int'(ref_v); ticks(1); r1 = int'(ref_v);
    check(r1 - r0 == SS_STEP, "R2", "soft-start step", r1 - r0, SS_STEP);
    seen_ready = 0; seen_hs = 0; reached = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (ready) seen_ready = 1;
      if (hs) seen_hs = 1;
      if (int'(ref_v) > TARGET) break;
      if (int'(ref_v) == TARGET) begin reached = 1; break; end
    end
    check(reached, "R2", "ref saturates at target", int'(ref_v), TARGET);
    check(!seen_ready, "R3", "ready low in soft start", int'(seen_ready), 0);
    check(seen_hs, "R11", "switching in soft start", int'(seen_hs), 1);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk);
      if (tick) n++;
      @(negedge clk);
      if (ready) break;
    end
    check(ready && n >= READY_US && n <= READY_US + 1, "R3", "ready delay ticks", n, READY_US);
    check(ref_v == W'(TARGET), "R2", "ref stays at target", int'(ref_v), TARGET);
  endtask

  task automatic test_gates();
    pwm_auto = 0; pwm = 1; cyc(6);
    check(hs && !ls, "R11", "hs follows pwm=1", int'({hs, ls}), 2);
    pwm = 0; cyc(6);
    check(!hs && ls, "R11", "ls follows pwm=0", int'({hs, ls}), 1);
    pwm_auto = 1;
  endtask

  task automatic test_uv();
    ofs = -300; cyc(4);
    check(ready, "R4", "gap of 300 keeps ready", int'(ready), 1);
    ofs = -301; cyc(4);
    check(!ready, "R4", "gap of 301 drops ready", int'(ready), 0);
    ofs = 0; cyc(4);
    check(ready, "R4", "ready returns", int'(ready), 1);
  endtask

  task automatic test_oc_slow();
    bit any;
    oc_slow = 1; ticks(OC_US - 3); oc_slow = 0; cyc(4);
    check(ready, "R5", "short slow OC ignored", int'(ready), 1);
    oc_slow = 1; ticks(OC_US + 3); cyc(4);
    check(!ready, "R5", "slow OC shutdown ready", int'(ready), 0);
    any = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (hs || ls) any = 1; end
    check(!any, "R5", "gates off after slow OC", int'(any), 0);
    oc_slow = 0; ticks(10);
    check(!ready && !hs && !ls, "R9", "OC latched after cause gone", int'(ready|hs|ls), 0);
    cycle_enable();
    bring_up("R9");
  endtask

  task automatic test_oc_fast();
    oc_fast = 1; cyc(1);
    check(!ready, "R6", "ready drops at next edge", int'(ready), 0);
    cyc(4);
    check(!hs && !ls, "R6", "gates off after fast OC", int'(hs|ls), 0);
    oc_fast = 0; ticks(5);
    check(!ready && !hs && !ls, "R9", "fast OC latched", int'(ready|hs|ls), 0);
    cycle_enable();
    bring_up("R6");
  endtask

  task automatic test_ov_run();
    int r0, r1;
    bit got0;
    ofs = 400; cyc(10);
    check(ready, "R7", "+400 does not trip", int'(ready), 1);
    vfix = W'(TARGET + 401); vmode = 1; cyc(6);
    check(!ready && !hs && ls, "R7", "OV trip in run", int'({ready, hs, ls}), 1);
    r0 = int'(ref_v); ticks(1); r1 = int'(ref_v);
    check(r0 - r1 == OV_STEP, "R8", "ref falls per tick", r0 - r1, OV_STEP);
    vfix = '0; cyc(6);
    check(!ls && !hs, "R8", "ls off below threshold", int'({hs, ls}), 0);
    got0 = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (ref_v == 0) begin got0 = 1; break; end
    end
    check(got0, "R8", "ref reaches zero", int'(ref_v), 0);
    cyc(6);
    check(ls && !hs, "R8", "ls clamped at zero ref", int'({hs, ls}), 1);
    ticks(5);
    check(ls && !ready, "R9", "OV latched", int'({ready, ls}), 1);
    cycle_enable();
    bring_up("R9");
  endtask

  task automatic test_soft_ov();
    bit seen, got;
    en = 0; cyc(3); en = 1;
    for (int i = 0; i < 1000; i++) begin @(negedge clk); if (ref_v > 100) break; end
    ofs = 500; seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (hs) seen = 1; end
    check(seen, "R7", "relative OV ignored in soft start", int'(seen), 1);
    ofs = 0;
    vfix = 12'd2950; vmode = 1; cyc(6);
    check(!hs && ls && !ready, "R7", "absolute OV in soft start", int'({ready, hs, ls}), 1);
    vmode = 0;
    wait_ready(got);
    check(got, "R7", "soft-start OV not latched", int'(ready), 1);
  endtask

  task automatic test_supply();
    bit got;
    vin_ok = 0; cyc(3);
    check(!ready && !hs && !ls && ref_v == 0, "R10", "supply loss shutdown",
          int'(ref_v) + int'(ready|hs|ls), 0);
    vin_ok = 1;
    ticks(STARTUP_US - 2);
    check(ref_v == 0, "R10", "restart delay", int'(ref_v), 0);
    wait_ready(got);
    check(got, "R10", "ready after supply return", int'(ready), 1);
  endtask

  initial begin
    test_reset();
    test_startup();
    test_gates();
    test_uv();
    test_oc_slow();
    test_oc_fast();
    test_ov_run();
    test_soft_ov();
    test_supply();
    check(overlap == 0, "R11", "gate overlap or no dead cycle", overlap, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule